// File: doc/BRIEF.md
# SPI flash command sequencer

This block runs one complete serial-flash command each time software sets a start bit. Software first places the instruction byte, the flash address and, for program-type commands, the outgoing payload in a word-organised buffer. It then writes one configuration word. That word says which optional phases follow the instruction byte (a three-byte address, up to seven dummy bytes, and a payload), which way the payload moves, how long it is, and which of two flash devices is selected. The sequencer then drives the serial pins in single-lane mode 0 until the command is finished.

Completion is signalled only by the start bit, which software polls. The bit reads 1 while the command runs and falls back to 0 by itself. For reads, the received payload is left in the same buffer, packed little-endian, four bytes per 32-bit word. The hardware version value is a parameter. It also sets the buffer depth: 64 words for version 0x351 and 16 words for any other value.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, both chip selects are high, the serial clock and MOSI are low, and the configuration word reads 0.
- R2: Offset 0x1F8 reads the version parameter. The buffer holds 64 words when the version is 0x351 and 16 otherwise. Buffer word n is at offset 0x400+4n. Reads from an offset past the last word return 0.
- R3: Configuration word at 0x300, with these fields: bit 0 start, bit 1 device select, bit 3 address phase on, bits 6:4 dummy byte count, bit 7 payload phase on, bit 8 direction (1 = flash to buffer), bits 16:9 payload length. The stored fields read back at the same positions. The instruction byte is at 0x308 and the address at 0x30C.
- R4: Bytes go out in this order: the instruction byte, then address bits 23:16, 15:8 and 7:0 (only when the address phase is on), then the programmed number of dummy bytes, then the payload (only when the payload phase is on). Dummy bytes, and the bytes sent during a read payload, are 0x00.
- R5: The length field holds the byte count minus one: 0 means one byte and 255 means 256 bytes.
- R6: Payload byte k belongs to buffer word k/4, at bits 8*(k mod 4)+7 down to 8*(k mod 4). A read payload changes only the bytes it covers. The other bytes of a partial final word keep their contents.
- R7: Every serial byte is sent and received most significant bit first. A write payload is taken from the buffer. A read payload is stored into the buffer.
- R8: Mode 0: the serial clock idles low. MOSI changes only while the clock is low. MISO is sampled on the rising edge.
- R9: Device select 0 drives cs_n[0] low and select 1 drives cs_n[1] low. At most one is low at a time. It falls before the first clock rise and rises after the last clock fall.
- R10: Start reads 1 while a command runs and clears by itself when the command ends.
- R11: Writes to any register or buffer word while a command runs are ignored. MISO bits received during the instruction, address and dummy bytes never reach the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| sck | output | 1 | Serial clock |
| cs_n | output | 2 | Active-low device selects |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |

## Verification
A wrong phase or counter state shows up on MOSI within one serial byte, about 16*SCK_HALF system cycles. The byte stream then has the wrong length, or a byte appears out of place. A stuck command state shows as a start bit that never clears, and the bench's polling loop catches it. A wrong buffer byte index or lane shows only when the buffer is read back after a read command. For that reason, every read case compares all buffer words, including the bytes the command must not touch.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
    localparam int NUM_CS = 2;

    localparam logic [11:0] OFS_VER = 12'h1F8;
    localparam logic [11:0] OFS_CFG = 12'h300;
    localparam logic [11:0] OFS_OPC = 12'h308;
    localparam logic [11:0] OFS_ADR = 12'h30C;

    typedef enum logic [2:0] {
        PH_IDLE, PH_SETUP, PH_OPC, PH_ADR, PH_DUM, PH_DAT, PH_HOLD
    } phase_e;

    typedef struct packed {
        logic [7:0] len_m1;
        logic       rd;
        logic       den;
        logic [2:0] dum;
        logic       aen;
        logic       csel;
    } cmd_cfg_t;

    typedef struct packed {
        phase_e     st;
        logic       issued;
        logic [7:0] cnt;
        cmd_cfg_t   cfg;
        logic [7:0] opc;
        logic [31:0] adr;
    } seq_t;

    function automatic logic [31:0] cfg_word(cmd_cfg_t c, logic running);
        return {15'b0, c.len_m1, c.rd, c.den, c.dum, c.aen, 1'b0, c.csel, running};
    endfunction
endpackage

// File: rtl/fsq_shifter.sv
module fsq_shifter #(
    parameter int HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte
);
    localparam int DW = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic          busy;
        logic          sck;
        logic          done;
        logic [2:0]    bitn;
        logic [DW-1:0] div;
        logic [7:0]    tx;
        logic [7:0]    rx;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d      = sh_q;
        sh_d.done = 1'b0;
        if (!sh_q.busy) begin
            if (start) begin
                sh_d.busy = 1'b1;
                sh_d.sck  = 1'b0;
                sh_d.bitn = 3'd0;
                sh_d.div  = '0;
                sh_d.tx   = tx_byte;
            end
        end else if (sh_q.div == DW'(HALF - 1)) begin
            sh_d.div = '0;
            if (!sh_q.sck) begin
                sh_d.sck = 1'b1;
                sh_d.rx  = {sh_q.rx[6:0], miso};
            end else begin
                sh_d.sck = 1'b0;
                if (sh_q.bitn == 3'd7) begin
                    sh_d.busy = 1'b0;
                    sh_d.done = 1'b1;
                end else begin
                    sh_d.bitn = sh_q.bitn + 3'd1;
                    sh_d.tx   = {sh_q.tx[6:0], 1'b0};
                end
            end
        end else begin
            sh_d.div = sh_q.div + DW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sck     = sh_q.sck;
    assign mosi    = sh_q.busy & sh_q.tx[7];
    assign done    = sh_q.done;
    assign rx_byte = sh_q.rx;
endmodule

// File: rtl/fsq_databuf.sv
module fsq_databuf #(
    parameter int WORDS = 64
) (
    input  logic                       clk,
    input  logic                       bus_we,
    input  logic [$clog2(WORDS)-1:0]   bus_widx,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    input  logic                       eng_we,
    input  logic [$clog2(WORDS)+1:0]   eng_bidx,
    input  logic [7:0]                 eng_wbyte,
    output logic [7:0]                 eng_rbyte
);
    localparam int WIW = $clog2(WORDS);

    logic [31:0] mem [WORDS];
    logic [31:0] eng_word;

    always_ff @(posedge clk) begin
        if (bus_we)
            mem[bus_widx] <= bus_wdata;
        else if (eng_we)
            mem[eng_bidx[WIW+1:2]][{eng_bidx[1:0], 3'b000} +: 8] <= eng_wbyte;
    end

    assign bus_rdata = mem[bus_widx];
    assign eng_word  = mem[eng_bidx[WIW+1:2]];
    assign eng_rbyte = eng_word[{eng_bidx[1:0], 3'b000} +: 8];
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter logic [31:0] HW_VERSION = 32'h351,
    parameter int          SCK_HALF   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              sck,
    output logic [NUM_CS-1:0] cs_n,
    output logic              mosi,
    input  logic              miso
);
    localparam int BUF_WORDS = (HW_VERSION == 32'h351) ? 64 : 16;
    localparam int WIW       = $clog2(BUF_WORDS);
    localparam int BIW       = WIW + 2;

    seq_t        seq_d, seq_q;
    logic        busy;
    logic        sh_start, sh_done;
    logic [7:0]  tx_byte, rx_byte, buf_byte;
    logic [31:0] buf_word;
    logic        buf_hit, buf_we, eng_we;
    logic        unused_ok;

    function automatic phase_e after_adr(cmd_cfg_t c);
        if (c.dum != 3'd0) return PH_DUM;
        if (c.den)         return PH_DAT;
        return PH_HOLD;
    endfunction

    function automatic phase_e after_opc(cmd_cfg_t c);
        if (c.aen) return PH_ADR;
        return after_adr(c);
    endfunction

    assign busy      = (seq_q.st != PH_IDLE);
    assign buf_hit   = (bus_addr[11:10] == 2'b01) && (bus_addr[1:0] == 2'b00)
                       && (bus_addr[9:2] < 8'(BUF_WORDS));
    assign buf_we    = bus_wr && !busy && buf_hit;
    assign eng_we    = (seq_q.st == PH_DAT) && seq_q.cfg.rd && sh_done;
    assign unused_ok = ^{bus_wdata[31:17], bus_wdata[2]};

    always_comb begin
        seq_d    = seq_q;
        sh_start = 1'b0;
        unique case (seq_q.st)
            PH_IDLE: begin
                if (bus_wr) begin
                    if (bus_addr == OFS_OPC) seq_d.opc = bus_wdata[7:0];
                    if (bus_addr == OFS_ADR) seq_d.adr = bus_wdata;
                    if (bus_addr == OFS_CFG) begin
                        seq_d.cfg.len_m1 = bus_wdata[16:9];
                        seq_d.cfg.rd     = bus_wdata[8];
                        seq_d.cfg.den    = bus_wdata[7];
                        seq_d.cfg.dum    = bus_wdata[6:4];
                        seq_d.cfg.aen    = bus_wdata[3];
                        seq_d.cfg.csel   = bus_wdata[1];
                        if (bus_wdata[0]) begin
                            seq_d.st     = PH_SETUP;
                            seq_d.cnt    = 8'd0;
                            seq_d.issued = 1'b0;
                        end
                    end
                end
            end
            PH_SETUP: seq_d.st = PH_OPC;
            PH_HOLD:  seq_d.st = PH_IDLE;
            default: begin
                if (!seq_q.issued) begin
                    sh_start     = 1'b1;
                    seq_d.issued = 1'b1;
                end else if (sh_done) begin
                    seq_d.issued = 1'b0;
                    seq_d.cnt    = seq_q.cnt + 8'd1;
                    case (seq_q.st)
                        PH_OPC: begin
                            seq_d.cnt = 8'd0;
                            seq_d.st  = after_opc(seq_q.cfg);
                        end
                        PH_ADR: if (seq_q.cnt == 8'd2) begin
                            seq_d.cnt = 8'd0;
                            seq_d.st  = after_adr(seq_q.cfg);
                        end
                        PH_DUM: if (seq_q.cnt == 8'(seq_q.cfg.dum) - 8'd1) begin
                            seq_d.cnt = 8'd0;
                            seq_d.st  = seq_q.cfg.den ? PH_DAT : PH_HOLD;
                        end
                        default: if (seq_q.cnt == seq_q.cfg.len_m1) begin
                            seq_d.st = PH_HOLD;
                        end
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    always_comb begin
        case (seq_q.st)
            PH_OPC:  tx_byte = seq_q.opc;
            PH_ADR:  tx_byte = (seq_q.cnt == 8'd0) ? seq_q.adr[23:16] :
                               (seq_q.cnt == 8'd1) ? seq_q.adr[15:8] : seq_q.adr[7:0];
            PH_DAT:  tx_byte = seq_q.cfg.rd ? 8'h00 : buf_byte;
            default: tx_byte = 8'h00;
        endcase
    end

    always_comb begin
        for (int i = 0; i < NUM_CS; i++)
            cs_n[i] = !(busy && (seq_q.cfg.csel == 1'(i)));
    end

    always_comb begin
        if (bus_addr == OFS_VER)      bus_rdata = HW_VERSION;
        else if (bus_addr == OFS_CFG) bus_rdata = cfg_word(seq_q.cfg, busy);
        else if (bus_addr == OFS_OPC) bus_rdata = {24'b0, seq_q.opc};
        else if (bus_addr == OFS_ADR) bus_rdata = seq_q.adr;
        else if (buf_hit)             bus_rdata = buf_word;
        else                          bus_rdata = 32'h0;
    end

    fsq_shifter #(.HALF(SCK_HALF)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sh_start),
        .tx_byte (tx_byte),
        .miso    (miso),
        .sck     (sck),
        .mosi    (mosi),
        .done    (sh_done),
        .rx_byte (rx_byte)
    );

    fsq_databuf #(.WORDS(BUF_WORDS)) u_buf (
        .clk       (clk),
        .bus_we    (buf_we),
        .bus_widx  (bus_addr[2 +: WIW]),
        .bus_wdata (bus_wdata),
        .bus_rdata (buf_word),
        .eng_we    (eng_we),
        .eng_bidx  (seq_q.cnt[BIW-1:0]),
        .eng_wbyte (rx_byte),
        .eng_rbyte (buf_byte)
    );
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sck,
    input logic        mosi,
    input logic [1:0]  cs_n,
    input logic        busy,
    input logic [14:0] cfg_bits
);
    a_r8_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (&cs_n) |-> !sck);

    a_r9_single_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    a_r8_mosi_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));

    a_r9_select_before_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> $past(!(&cs_n)));

    a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cfg_bits));
endmodule

bind flash_cmd_seq flash_cmd_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck      (sck),
    .mosi     (mosi),
    .cs_n     (cs_n),
    .busy     (busy),
    .cfg_bits (seq_q.cfg)
);

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;
    import flash_seq_pkg::*;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [7:0]  opc;
        logic [23:0] adr;
        logic        aen;
        logic [2:0]  dum;
        logic        den;
        logic        rd;
        logic [7:0]  len;
        logic        cs;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{8'h9F, 24'h000000, 1'b0, 3'd0, 1'b1, 1'b1, 8'd2, 1'b0},
        '{8'h03, 24'h123456, 1'b1, 3'd0, 1'b1, 1'b1, 8'd6, 1'b0},
        '{8'h0B, 24'hABCDEF, 1'b1, 3'd1, 1'b1, 1'b1, 8'd4, 1'b1},
        '{8'h02, 24'h00F00D, 1'b1, 3'd0, 1'b1, 1'b0, 8'd9, 1'b0},
        '{8'h06, 24'h000000, 1'b0, 3'd0, 1'b0, 1'b0, 8'd0, 1'b1},
        '{8'hD8, 24'h7F0000, 1'b1, 3'd0, 1'b0, 1'b0, 8'd0, 1'b0},
        '{8'h3B, 24'h000100, 1'b1, 3'd7, 1'b1, 1'b1, 8'd0, 1'b1}
    };

    logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, miso = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    wire  [31:0] bus_rdata;
    wire         sck, mosi;
    wire  [1:0]  cs_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_seq dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck(sck),
        .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mpat(int j);
        return 8'(j * 37 + 90) ^ 8'h3C;
    endfunction

    function automatic logic mbit(int p);
        logic [7:0] b;
        b = mpat(p / 8);
        return b[7 - (p % 8)];
    endfunction

    // flash model: capture MOSI on rise, present MISO after fall
    int         bitpos = 0;
    logic [7:0] cap [0:299];
    always @(posedge sck) begin
        if (bitpos < 2400) cap[bitpos / 8] = {cap[bitpos / 8][6:0], mosi};
        bitpos++;
    end
    always @(negedge sck) miso = mbit(bitpos);

    int cs0_fall = 0, cs1_fall = 0;
    always @(negedge cs_n[0]) cs0_fall++;
    always @(negedge cs_n[1]) cs1_fall++;

    int   mode_bad = 0;
    logic psck = 1'b0, pmosi = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (psck && sck && (mosi !== pmosi)) mode_bad++;
            if ((&cs_n) && sck) mode_bad++;
        end
        psck  = sck;
        pmosi = mosi;
    end

    logic [7:0] bb [0:255];

    task automatic bwrite(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bread(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [31:0] enc(vec_t v, logic st);
        return {15'b0, v.len, v.rd, v.den, v.dum, v.aen, 1'b0, v.cs, st};
    endfunction

    task automatic load_buf(int seed);
        for (int k = 0; k < 256; k++) bb[k] = 8'(k * 13 + seed);
        for (int w = 0; w < 64; w++)
            bwrite(12'(12'h400 + w * 4), {bb[4*w+3], bb[4*w+2], bb[4*w+1], bb[4*w]});
    endtask

    int c0_base, c1_base;

    task automatic launch(vec_t v);
        bitpos  = 0;
        miso    = mbit(0);
        c0_base = cs0_fall;
        c1_base = cs1_fall;
        bwrite(OFS_OPC, {24'b0, v.opc});
        bwrite(OFS_ADR, {8'h00, v.adr});
        bwrite(OFS_CFG, enc(v, 1'b1));
    endtask

    task automatic finish_and_verify(vec_t v, string nm);
        logic [31:0] r;
        logic [7:0]  e [0:299];
        int          n, hdr, bad_i;
        r = 32'h1;
        for (int i = 0; i < 30000 && r[0]; i++) bread(OFS_CFG, r);
        check({nm, " R10 start self-clears"}, {31'b0, r[0]}, 32'h0);
        n = 0;
        e[n] = v.opc; n++;
        if (v.aen) begin
            e[n] = v.adr[23:16]; e[n+1] = v.adr[15:8]; e[n+2] = v.adr[7:0]; n += 3;
        end
        for (int i = 0; i < int'(v.dum); i++) begin e[n] = 8'h00; n++; end
        hdr = n;
        if (v.den)
            for (int k = 0; k <= int'(v.len); k++) begin
                e[n] = v.rd ? 8'h00 : bb[k]; n++;
            end
        check({nm, " R5 serial bit count"}, 32'(bitpos), 32'(n * 8));
        bad_i = -1;
        for (int i = 0; i < n; i++) if (bad_i < 0 && cap[i] !== e[i]) bad_i = i;
        if (bad_i < 0) check({nm, " R4 R7 mosi bytes"}, 32'h0, 32'h0);
        else check({nm, " R4 R7 mosi bytes"}, {24'b0, cap[bad_i]}, {24'b0, e[bad_i]});
        check({nm, " R9 selected device"},
              {cs1_fall - c1_base == 1, cs0_fall - c0_base == 1},
              v.cs ? 32'h2 : 32'h1);
        if (v.den && v.rd) begin
            for (int k = 0; k <= int'(v.len); k++) bb[k] = mpat(hdr + k);
            bad_i = -1;
            for (int w = 0; w < 64; w++) begin
                bread(12'(12'h400 + w * 4), r);
                if (bad_i < 0 && r !== {bb[4*w+3], bb[4*w+2], bb[4*w+1], bb[4*w]}) begin
                    bad_i = w;
                    check({nm, " R6 R7 R11 read buffer"}, r,
                          {bb[4*w+3], bb[4*w+2], bb[4*w+1], bb[4*w]});
                end
            end
            if (bad_i < 0) check({nm, " R6 R7 R11 read buffer"}, 32'h0, 32'h0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        vec_t        v;
        repeat (3) @(negedge clk);
        check("R1 cs_n in reset", {30'b0, cs_n}, 32'h3);
        check("R1 sck/mosi in reset", {30'b0, sck, mosi}, 32'h0);
        rst_n = 1'b1;
        bread(OFS_CFG, r);
        check("R1 R3 config after reset", r, 32'h0);

        bread(OFS_VER, r);
        check("R2 version", r, 32'h351);
        bwrite(12'h4FC, 32'hC0FFEE11);
        bread(12'h4FC, r);
        check("R2 last buffer word", r, 32'hC0FFEE11);
        bread(12'h500, r);
        check("R2 past buffer end", r, 32'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            load_buf(i * 5 + 1);
            if (i == 0) begin
                // partial word: preset word 0 to known pattern already via load_buf
            end
            launch(VECS[i]);
            finish_and_verify(VECS[i], $sformatf("vec%0d", i));
        end

        // R6 one-byte read keeps upper bytes of word 0
        load_buf(77);
        v = '{8'h05, 24'h0, 1'b0, 3'd0, 1'b1, 1'b1, 8'd0, 1'b0};
        launch(v);
        finish_and_verify(v, "R6 single byte");
        bread(12'h400, r);
        check("R6 partial word low lane", r, {bb[3], bb[2], bb[1], mpat(1)});

        // R3 R10 R11 R5: max length, readback while busy, writes ignored
        load_buf(200);
        v = '{8'h02, 24'h010203, 1'b1, 3'd0, 1'b1, 1'b0, 8'd255, 1'b1};
        launch(v);
        bread(OFS_CFG, r);
        check("R10 R3 busy readback", r, enc(v, 1'b1));
        bwrite(OFS_CFG, 32'h0001_FFFB);
        bwrite(OFS_OPC, 32'h77);
        bwrite(12'h4F0, 32'hDEADBEEF);
        bread(OFS_CFG, r);
        check("R11 config write ignored while busy", r, enc(v, 1'b1));
        finish_and_verify(v, "R5 max length");
        bread(OFS_OPC, r);
        check("R11 opcode write ignored", r, {24'b0, v.opc});
        bread(12'h4F0, r);
        check("R11 buffer write ignored", r, {bb[243], bb[242], bb[241], bb[240]});
        check("R11 no second command", 32'(cs0_fall - c0_base), 32'h0);

        check("R8 mode 0 timing", 32'(mode_bad), 32'h0);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule